// File: doc/BRIEF.md
# Ethernet MAC statistics counters

This block keeps two statistics counters for an Ethernet MAC. Software can read and write both through a small register port. The first counter records transmitted frames that went out successfully after a moderate number of collisions. The second counter records received frames that passed every test for a good frame: the address matched, the frame was stored to memory, no receive error was flagged, and the length falls inside the legal window.

The transmit and receive engines report each frame with a single-cycle status strobe. These strobes carry valid-only semantics. There is no back-pressure: the block takes a strobe on every cycle it is high and never stalls the reporting engine, so the engines need no ready signal. A configuration input moves the upper length limit, so that frames carrying a VLAN tag can be counted.

The register port is plain. A write takes effect at the clock edge. A read is combinational on the address, so the data is valid in the same cycle.

Top module: `eth_frame_stats`

## Requirements
- R1: After reset, both counters read as zero.
- R2: A transmit strobe (`tx_done`=1) with `tx_ok`=1 and a collision count from 2 to 15 inclusive raises the multiple-collision counter by exactly one at the next clock edge.
- R3: A transmit strobe with 0, 1, or 16 or more collisions, or with `tx_ok`=0, leaves the multiple-collision counter unchanged.
- R4: A receive strobe (`rx_done`=1) with address hit, stored-to-memory, no error flags and a legal length raises the good-frame counter by exactly one at the next clock edge.
- R5: The length limits are inclusive. The minimum is 64 bytes. The maximum is 1518 bytes when `cfg_long_frames`=0 and 1522 bytes when it is 1. A frame shorter or longer than these limits is not counted.
- R6: A frame is not counted if any of the following holds: its FCS, alignment or symbol error flag is set, its address did not match, or it was not stored.
- R7: Reading byte offset 0x48 returns the multiple-collision counter in bits 15:0. Reading 0x4C returns the good-frame counter in bits 23:0. All other bits of these two registers read 0, and every other offset reads 0.
- R8: A write to 0x48 or 0x4C loads the counter field from the low bits of `reg_wdata`. The reserved write bits are ignored. A write to any other offset changes nothing.
- R9: When a software write and a qualifying frame hit the same counter in the same cycle, the written value is kept and the increment is dropped.
- R10: Each counter stops at all ones. A qualifying frame at that value leaves the counter unchanged and does not wrap it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done | input | 1 | Transmit completion strobe, one cycle per frame |
| tx_ok | input | 1 | Frame was transmitted successfully |
| tx_coll | input | 5 | Number of collisions seen by the frame |
| rx_done | input | 1 | Receive end-of-frame strobe, one cycle per frame |
| rx_len | input | 11 | Received frame length in bytes |
| rx_addr_hit | input | 1 | Destination address was recognized |
| rx_stored | input | 1 | Frame was copied to memory without problems |
| rx_fcs_err | input | 1 | Frame check sequence error |
| rx_align_err | input | 1 | Alignment error |
| rx_sym_err | input | 1 | Receive symbol error |
| cfg_long_frames | input | 1 | 1 raises the maximum good length to 1522 bytes |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |

## Verification
The bench sweeps every collision count from 0 to 31 with both success values. A design with an off-by-one at either end of the window would count the 1- or 16-collision case, or miss the 2- or 15-collision case. Every receive length from 0 to 2047 is tried under both length settings, so a limit taken as exclusive, or a configuration bit that is ignored, shows up at 63/64, 1518/1519 or 1522/1523. All 32 combinations of the qualifying and error flags are sent. Separate cases target the following:
- an increment racing a write, where a design giving the increment priority would return the written value plus one;
- a counter already at all ones, where a wrapping design would return zero;
- writes of all ones, where leaking reserved bits would make them read back nonzero.

// File: rtl/eth_stats_pkg.sv
package eth_stats_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam logic [REG_AW-1:0] OFS_MULTI_COLL = 8'h48;
  localparam logic [REG_AW-1:0] OFS_RX_GOOD    = 8'h4C;

  typedef struct packed {
    logic addr_hit;
    logic stored;
    logic fcs_err;
    logic align_err;
    logic sym_err;
  } rx_flags_t;
endpackage

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (wr_en)              cnt <= wdata;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wdata)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !wr_en) |=> cnt == TOP); // R10

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/tx_coll_qual.sv
module tx_coll_qual #(
  parameter int COLL_W = 5,
  parameter int LO     = 2,
  parameter int HI     = 15
) (
  input  logic              done,
  input  logic              ok,
  input  logic [COLL_W-1:0] coll,
  output logic              hit
);
  localparam logic [COLL_W-1:0] LO_V = COLL_W'(LO);
  localparam logic [COLL_W-1:0] HI_V = COLL_W'(HI);

  always_comb hit = done && ok && (coll >= LO_V) && (coll <= HI_V);
endmodule

// File: rtl/rx_good_qual.sv
module rx_good_qual
  import eth_stats_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_STD = 1518,
  parameter int MAX_EXT = 1522
) (
  input  logic             done,
  input  logic [LEN_W-1:0] len,
  input  logic             long_ok,
  input  rx_flags_t        flags,
  output logic             good
);
  localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_V = LEN_W'(MAX_STD);
  localparam logic [LEN_W-1:0] EXT_V = LEN_W'(MAX_EXT);

  logic [LEN_W-1:0] max_v;
  logic             len_ok;
  logic             clean;

  always_comb begin
    max_v  = long_ok ? EXT_V : STD_V;
    len_ok = (len >= MIN_V) && (len <= max_v);
    clean  = flags.addr_hit && flags.stored &&
             !(flags.fcs_err || flags.align_err || flags.sym_err);
    good   = done && len_ok && clean;
  end
endmodule

// File: rtl/eth_frame_stats.sv
module eth_frame_stats
  import eth_stats_pkg::*;
#(
  parameter int COLL_W  = 5,
  parameter int LEN_W   = 11,
  parameter int MC_W    = 16,
  parameter int RX_W    = 24,
  parameter int MIN_LEN = 64,
  parameter int MAX_STD = 1518,
  parameter int MAX_EXT = 1522
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_done,
  input  logic              tx_ok,
  input  logic [COLL_W-1:0] tx_coll,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_addr_hit,
  input  logic              rx_stored,
  input  logic              rx_fcs_err,
  input  logic              rx_align_err,
  input  logic              rx_sym_err,
  input  logic              cfg_long_frames,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);

  logic            sel_mc, sel_rx;
  logic            mc_hit, rx_hit;
  logic [MC_W-1:0] mc_cnt;
  logic [RX_W-1:0] rx_cnt;
  rx_flags_t       flags;

  always_comb begin
    sel_mc = (reg_addr == OFS_MULTI_COLL);
    sel_rx = (reg_addr == OFS_RX_GOOD);
    flags  = '{addr_hit: rx_addr_hit, stored: rx_stored, fcs_err: rx_fcs_err,
               align_err: rx_align_err, sym_err: rx_sym_err};
  end

  tx_coll_qual #(.COLL_W(COLL_W), .LO(2), .HI(15)) u_txq (
    .done(tx_done), .ok(tx_ok), .coll(tx_coll), .hit(mc_hit)
  );

  rx_good_qual #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD),
                 .MAX_EXT(MAX_EXT)) u_rxq (
    .done(rx_done), .len(rx_len), .long_ok(cfg_long_frames),
    .flags(flags), .good(rx_hit)
  );

  stat_sat_counter #(.W(MC_W)) u_mc_cnt (
    .clk(clk), .rst_n(rst_n), .inc(mc_hit), .wr_en(reg_wr && sel_mc),
    .wdata(reg_wdata[MC_W-1:0]), .cnt(mc_cnt)
  );

  stat_sat_counter #(.W(RX_W)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .inc(rx_hit), .wr_en(reg_wr && sel_rx),
    .wdata(reg_wdata[RX_W-1:0]), .cnt(rx_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_mc)      reg_rdata = {{(32-MC_W){1'b0}}, mc_cnt};
    else if (sel_rx) reg_rdata = {{(32-RX_W){1'b0}}, rx_cnt};
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_mc && !sel_rx) |-> reg_rdata == 32'h0); // R7

  AST_TX_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_ok && !(reg_wr && sel_mc)) |=> $stable(mc_cnt)); // R3

  AST_RX_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && (rx_fcs_err || rx_align_err || rx_sym_err) && !(reg_wr && sel_rx))
      |=> $stable(rx_cnt)); // R6

  AST_RX_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_len < MIN_V && !(reg_wr && sel_rx)) |=> $stable(rx_cnt)); // R5
endmodule

// File: tb/tb_eth_frame_stats.sv
`timescale 1ns/1ps
module tb_eth_frame_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_done = 0, tx_ok = 0;
  logic [4:0]  tx_coll = 0;
  logic        rx_done = 0;
  logic [10:0] rx_len = 0;
  logic        rx_addr_hit = 0, rx_stored = 0, rx_fcs_err = 0;
  logic        rx_align_err = 0, rx_sym_err = 0, cfg_long_frames = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eth_frame_stats dut (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_ok(tx_ok), .tx_coll(tx_coll),
    .rx_done(rx_done), .rx_len(rx_len), .rx_addr_hit(rx_addr_hit),
    .rx_stored(rx_stored), .rx_fcs_err(rx_fcs_err), .rx_align_err(rx_align_err),
    .rx_sym_err(rx_sym_err), .cfg_long_frames(cfg_long_frames),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic tx(input logic ok, input logic [4:0] c);
    @(negedge clk);
    tx_done = 1; tx_ok = ok; tx_coll = c;
    @(negedge clk);
    tx_done = 0;
  endtask

  task automatic rx(input int len, input logic [4:0] fl);
    @(negedge clk);
    rx_done = 1; rx_len = 11'(len);
    {rx_addr_hit, rx_stored, rx_fcs_err, rx_align_err, rx_sym_err} = fl;
    @(negedge clk);
    rx_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int exp_mc, exp_rx, maxl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h48, d); chk("R1 mc reset", d, 0);
    rd(8'h4C, d); chk("R1 rx reset", d, 0);

    // R2 R3: collision window sweep
    exp_mc = 0;
    for (int c = 0; c < 32; c++)
      for (int ok = 0; ok < 2; ok++) begin
        tx(ok[0], 5'(c));
        if (ok == 1 && c >= 2 && c <= 15) exp_mc++;
        rd(8'h48, d);
        chk((ok == 1 && c >= 2 && c <= 15) ? "R2 tx count" : "R3 tx ignored", d, exp_mc);
      end

    // R4 R5: length sweep under both limits
    exp_rx = 0;
    for (int e = 0; e < 2; e++) begin
      cfg_long_frames = e[0];
      maxl = e ? 1522 : 1518;
      for (int l = 0; l < 2048; l++) begin
        rx(l, 5'b11000);
        if (l >= 64 && l <= maxl) exp_rx++;
        rd(8'h4C, d);
        chk((l >= 64 && l <= maxl) ? "R4 rx good" : "R5 rx length", d, exp_rx);
      end
    end
    cfg_long_frames = 0;

    // R6: flag combinations
    for (int fl = 0; fl < 32; fl++) begin
      rx(500, 5'(fl));
      if (fl == 24) exp_rx++;
      rd(8'h4C, d);
      chk("R6 rx flags", d, exp_rx);
    end

    // R9: write racing increment
    @(negedge clk);
    reg_addr = 8'h48; reg_wdata = 32'h7; reg_wr = 1;
    tx_done = 1; tx_ok = 1; tx_coll = 5'd3;
    @(negedge clk);
    reg_wr = 0; tx_done = 0;
    rd(8'h48, d); chk("R9 mc write wins", d, 32'h7);
    @(negedge clk);
    reg_addr = 8'h4C; reg_wdata = 32'h55; reg_wr = 1;
    rx_done = 1; rx_len = 11'd100; {rx_addr_hit, rx_stored, rx_fcs_err, rx_align_err, rx_sym_err} = 5'b11000;
    @(negedge clk);
    reg_wr = 0; rx_done = 0;
    rd(8'h4C, d); chk("R9 rx write wins", d, 32'h55);

    // R10: saturation
    wr(8'h48, 32'h0000_FFFE);
    tx(1, 5'd2); rd(8'h48, d); chk("R10 mc reach top", d, 32'hFFFF);
    tx(1, 5'd15); rd(8'h48, d); chk("R10 mc hold top", d, 32'hFFFF);
    wr(8'h4C, 32'h00FF_FFFE);
    rx(64, 5'b11000); rd(8'h4C, d); chk("R10 rx reach top", d, 32'hFF_FFFF);
    rx(1518, 5'b11000); rd(8'h4C, d); chk("R10 rx hold top", d, 32'hFF_FFFF);

    // R7 R8: reserved bits and map
    wr(8'h48, 32'hFFFF_1234); rd(8'h48, d); chk("R8 mc reserved write", d, 32'h1234);
    wr(8'h4C, 32'hFFAB_CDEF); rd(8'h4C, d); chk("R8 rx reserved write", d, 32'hAB_CDEF);
    wr(8'h44, 32'h1234_5678);
    rd(8'h48, d); chk("R8 other write mc", d, 32'h1234);
    rd(8'h4C, d); chk("R8 other write rx", d, 32'hAB_CDEF);
    rd(8'h44, d); chk("R7 unmapped 44", d, 0);
    rd(8'h00, d); chk("R7 unmapped 00", d, 0);
    rd(8'hFC, d); chk("R7 unmapped FC", d, 0);
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, d); chk("R7 mc upper zero", d, 32'h0000_FFFF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule